// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This block turns an interrupt vector number into a handler target. On a request strobe it captures the vector, the operating mode and the descriptor-table register (base and limit). It then reads the vector's entry from memory through a 32-bit read port and reports the handler's segment or selector, its offset, whether further hardware interrupts must be masked, and whether the entry asks for a task switch. A one-cycle `done` pulse marks the point where the results are valid.

In real mode the table is fixed in the first kilobyte of memory. It holds one 4-byte pointer per vector, so a single read completes the fetch. In protected mode the table can sit anywhere in memory, and each vector owns an 8-byte gate descriptor. The block first checks the descriptor against the table limit, then reads both words of the gate and decodes it. The core that uses the block pushes the stack frame and performs any task switch.

Top module: `ivec_fetch_unit`

## Requirements
- R1: After reset, `done`, `fault`, `mem_req`, `mask_irq` and `task_gate` are 0, and `handler_sel` and `handler_off` are zero.
- R2: In real mode (`prot_mode`=0) the block issues exactly one read, at byte address vector×4, whatever `tbl_base` holds. It reports `handler_off` = {16'h0, data[15:0]} and `handler_sel` = data[31:16], with `mask_irq`=1, `task_gate`=0 and `fault`=0.
- R3: In protected mode the block issues two reads, first at `tbl_base` + vector×8 (low word) and then at that address + 4 (high word).
- R4: In protected mode, if vector×8+7 exceeds `tbl_limit`, the block reports `fault`=1 with no memory read. A descriptor whose last byte equals the limit is accepted.
- R5: The gate type sits in high-word bits [11:8] and the present flag in high-word bit 15. A present gate of type 4'hE (interrupt gate) reports `mask_irq`=1. For every accepted gate, `handler_sel` = low[31:16] and `handler_off` = {high[31:16], low[15:0]}.
- R6: A present gate of type 4'hF (trap gate) reports `mask_irq`=0, `task_gate`=0 and `fault`=0.
- R7: A present gate of type 4'h5 (task gate) reports `task_gate`=1, `mask_irq`=0 and `fault`=0.
- R8: A descriptor with the present bit clear reports `fault`=1, with `mask_irq`=0 and `task_gate`=0.
- R9: A present descriptor whose type is none of 4'hE, 4'hF or 4'h5 reports `fault`=1.
- R10: A request strobe that arrives while a fetch is in progress is ignored. It does not change the results, start another read or produce another `done`.
- R11: `done` is high for exactly one cycle per accepted request, and the result outputs hold their values until the next fetch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_vector | input | 8 | Interrupt vector number |
| prot_mode | input | 1 | 1 = protected-mode gate table, 0 = real-mode pointer table |
| tbl_base | input | 32 | Byte base address of the protected-mode table |
| tbl_limit | input | 16 | Last valid byte offset of the protected-mode table |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle pulse: results valid |
| fault | output | 1 | Fetch failed (limit, not present or bad type) |
| handler_sel | output | 16 | Handler segment (real) or selector (protected) |
| handler_off | output | 32 | Handler offset |
| mask_irq | output | 1 | Core must mask further hardware interrupts |
| task_gate | output | 1 | Entry requests a task switch |

## Verification
The request is sampled at a clock edge. The bench's memory answers one cycle after each read request. Under those conditions `done` is due 2 cycles after the request edge for a limit fault, 4 cycles after it for a real-mode fetch, and 6 cycles after it for any protected fetch that reaches memory (this includes present-bit and type faults). Every scenario counts cycles from the request edge to `done`, compares the count with these values, and reads the results in that same cycle at the falling edge. The request-ignored case injects a second strobe during the memory wait. It then watches eight more cycles for any extra read or pulse.

// File: rtl/ivf_pkg.sv
// Package: shared types and constants for the interrupt vector fetch unit.
// Assumes a 32-bit memory data path; the gate codes are fixed encodings.
package ivf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH
    } fetch_state_t;

    localparam logic [3:0] GATE_INTR = 4'hE;
    localparam logic [3:0] GATE_TRAP = 4'hF;
    localparam logic [3:0] GATE_TASK = 4'h5;

    localparam int PRESENT_BIT = 15;
    localparam int TYPE_LSB    = 8;

    typedef struct packed {
        logic        fault;
        logic        mask;
        logic        task_sw;
        logic [15:0] sel;
        logic [31:0] off;
    } fetch_result_t;

endpackage

// File: rtl/ivf_addr_gen.sv
// Module: computes the byte address of the table word to read and the
// protected-mode limit test. Assumes the real-mode table starts at zero.
module ivf_addr_gen #(
    parameter int VEC_W   = 8,
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 16
) (
    input  logic [VEC_W-1:0]   vector,
    input  logic               prot,
    input  logic [ADDR_W-1:0]  base,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               word_idx,
    output logic [ADDR_W-1:0]  addr,
    output logic               limit_fail
);
    localparam int REAL_SHIFT = 2;
    localparam int PROT_SHIFT = 3;
    localparam int CMP_W      = ((VEC_W + PROT_SHIFT) > LIMIT_W) ?
                                (VEC_W + PROT_SHIFT) : LIMIT_W;

    logic [ADDR_W-1:0] real_addr;
    logic [ADDR_W-1:0] prot_addr;
    logic [CMP_W-1:0]  last_byte;
    logic [CMP_W-1:0]  limit_ext;

    // Build the word address for the selected table format.
    always_comb begin
        real_addr = ADDR_W'({vector, {REAL_SHIFT{1'b0}}});
        prot_addr = base + ADDR_W'({vector, {PROT_SHIFT{1'b0}}})
                         + (word_idx ? ADDR_W'(4) : ADDR_W'(0));
        addr      = prot ? prot_addr : real_addr;
    end

    // Compare the descriptor's last byte offset with the table limit.
    always_comb begin
        last_byte  = CMP_W'({vector, {PROT_SHIFT{1'b1}}});
        limit_ext  = CMP_W'(limit);
        limit_fail = prot && (last_byte > limit_ext);
    end

endmodule

// File: rtl/ivf_gate_decode.sv
// Module: turns a fetched table entry into handler target and control flags.
// Assumes lo_word/hi_word are valid when the caller samples the result;
// in real mode only lo_word is used.
module ivf_gate_decode
    import ivf_pkg::*;
(
    input  logic          prot,
    input  logic [31:0]   lo_word,
    input  logic [31:0]   hi_word,
    output fetch_result_t result
);
    logic [3:0] gtype;
    logic       present;

    // Extract the gate fields from the high word.
    always_comb begin
        gtype   = hi_word[TYPE_LSB +: 4];
        present = hi_word[PRESENT_BIT];
    end

    // Decode the entry into target and flags.
    always_comb begin
        result = '0;
        if (!prot) begin
            result.sel  = lo_word[31:16];
            result.off  = {16'h0000, lo_word[15:0]};
            result.mask = 1'b1;
        end else if (!present) begin
            result.fault = 1'b1;
        end else begin
            unique case (gtype)
                GATE_INTR: begin
                    result.sel  = lo_word[31:16];
                    result.off  = {hi_word[31:16], lo_word[15:0]};
                    result.mask = 1'b1;
                end
                GATE_TRAP: begin
                    result.sel = lo_word[31:16];
                    result.off = {hi_word[31:16], lo_word[15:0]};
                end
                GATE_TASK: begin
                    result.sel     = lo_word[31:16];
                    result.off     = {hi_word[31:16], lo_word[15:0]};
                    result.task_sw = 1'b1;
                end
                default: result.fault = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/ivec_fetch_unit.sv
// Module: interrupt vector fetch unit top. It captures a request, checks
// the limit, reads one (real) or two (protected) table words and reports
// the handler. Assumes memory returns each read with mem_rvalid some cycle
// after mem_req, one read outstanding at a time.
module ivec_fetch_unit
    import ivf_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VEC_W-1:0]   req_vector,
    input  logic               prot_mode,
    input  logic [ADDR_W-1:0]  tbl_base,
    input  logic [LIMIT_W-1:0] tbl_limit,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata,
    output logic               done,
    output logic               fault,
    output logic [15:0]        handler_sel,
    output logic [31:0]        handler_off,
    output logic               mask_irq,
    output logic               task_gate
);
    localparam int REAL_TBL_BITS = 10;

    fetch_state_t       state_q;
    logic [VEC_W-1:0]   vec_q;
    logic               prot_q;
    logic [ADDR_W-1:0]  base_q;
    logic [LIMIT_W-1:0] limit_q;
    logic               word_idx_q;
    logic [31:0]        lo_q;
    fetch_result_t      res_q;

    logic               limit_fail;
    logic [31:0]        dec_lo;
    fetch_result_t      dec_res;
    fetch_result_t      limit_res;

    ivf_addr_gen #(
        .VEC_W  (VEC_W),
        .ADDR_W (ADDR_W),
        .LIMIT_W(LIMIT_W)
    ) u_addr (
        .vector    (vec_q),
        .prot      (prot_q),
        .base      (base_q),
        .limit     (limit_q),
        .word_idx  (word_idx_q),
        .addr      (mem_addr),
        .limit_fail(limit_fail)
    );

    // Low word comes from the holding register once the high word arrives.
    always_comb dec_lo = word_idx_q ? lo_q : mem_rdata;

    ivf_gate_decode u_dec (
        .prot   (prot_q),
        .lo_word(dec_lo),
        .hi_word(mem_rdata),
        .result (dec_res)
    );

    // Result reported for a descriptor beyond the table limit.
    always_comb begin
        limit_res       = '0;
        limit_res.fault = 1'b1;
    end

    // Fetch sequencer: capture, limit check, reads, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            vec_q      <= '0;
            prot_q     <= 1'b0;
            base_q     <= '0;
            limit_q    <= '0;
            word_idx_q <= 1'b0;
            lo_q       <= '0;
            res_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vec_q      <= req_vector;
                        prot_q     <= prot_mode;
                        base_q     <= tbl_base;
                        limit_q    <= tbl_limit;
                        word_idx_q <= 1'b0;
                        state_q    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (limit_fail) begin
                        res_q   <= limit_res;
                        state_q <= ST_FINISH;
                    end else begin
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (prot_q && !word_idx_q) begin
                            lo_q       <= mem_rdata;
                            word_idx_q <= 1'b1;
                            state_q    <= ST_ISSUE;
                        end else begin
                            res_q   <= dec_res;
                            state_q <= ST_FINISH;
                        end
                    end
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory request and the result ports.
    always_comb begin
        mem_req     = (state_q == ST_ISSUE);
        done        = (state_q == ST_FINISH);
        fault       = res_q.fault;
        mask_irq    = res_q.mask;
        task_gate   = res_q.task_sw;
        handler_sel = res_q.sel;
        handler_off = res_q.off;
    end

    // R11: completion pulse lasts a single cycle.
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: a limit failure finishes with a fault and no read.
    assert_limit_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && limit_fail) |=> (done && fault && !mem_req));

    // R2: real-mode reads stay inside the first kilobyte.
    assert_real_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !prot_q) |-> (mem_addr[ADDR_W-1:REAL_TBL_BITS] == '0));

    // R10: captured vector does not move while a fetch is busy.
    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(vec_q));

    // R7: task switch and interrupt masking never reported together.
    assert_task_no_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(mask_irq && task_gate));

    // R8: a faulting fetch carries no control flags.
    assert_fault_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (!mask_irq && !task_gate));

endmodule

// File: tb/test_ivec_fetch_unit.sv
// Directed bench for the interrupt vector fetch unit: one task per scenario,
// with a memory model that answers each read one cycle later.
module test_ivec_fetch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic        prot_mode = 1'b0;
    logic [31:0] tbl_base = '0;
    logic [15:0] tbl_limit = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, fault, mask_irq, task_gate;
    logic [15:0] handler_sel;
    logic [31:0] handler_off;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mem [0:1023];
    logic [31:0] rd_log [0:7];
    int nreads = 0;
    int ndone  = 0;

    always #5 clk = ~clk;

    ivec_fetch_unit i_ivec_fetch_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .prot_mode(prot_mode), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .handler_sel(handler_sel), .handler_off(handler_off),
        .mask_irq(mask_irq), .task_gate(task_gate)
    );

    // Memory model with one cycle of latency, plus read and done logging.
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem[mem_addr[11:2]];
        if (mem_req) begin
            if (nreads < 8) rd_log[nreads] = mem_addr;
            nreads = nreads + 1;
        end
        if (done) ndone = ndone + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request; return the cycles until done (0 on timeout).
    task automatic fetch(input logic [7:0] vec, input logic prot,
                         input logic [31:0] base, input logic [15:0] lim,
                         input bit poke, input logic [7:0] pvec, output int cyc);
        @(negedge clk);
        nreads = 0; ndone = 0;
        req_valid = 1'b1; req_vector = vec; prot_mode = prot;
        tbl_base = base; tbl_limit = lim;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        for (int k = 1; k <= 40; k++) begin
            if (done) begin cyc = k; break; end
            if (poke && k == 3) begin
                req_valid = 1'b1; req_vector = pvec; prot_mode = 1'b0;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic check_target(input string tag, input logic [15:0] sel,
                                input logic [31:0] off, input logic m,
                                input logic t, input logic f);
        chk(handler_sel == sel, {tag, " sel"}, handler_sel, sel);
        chk(handler_off == off, {tag, " off"}, handler_off, off);
        chk(mask_irq == m, {tag, " mask"}, mask_irq, m);
        chk(task_gate == t, {tag, " task"}, task_gate, t);
        chk(fault == f, {tag, " fault"}, fault, f);
    endtask

    task automatic test_reset();
        chk(!done && !fault && !mem_req, "R1 ctrl", {done, fault, mem_req}, 0);
        chk(!mask_irq && !task_gate, "R1 flags", {mask_irq, task_gate}, 0);
        chk(handler_sel == 0 && handler_off == 0, "R1 target",
            {handler_sel, handler_off}, 0);
    endtask

    task automatic test_real();
        int c;
        fetch(8'h21, 1'b0, 32'h0000_0800, 16'h0, 1'b0, 8'h0, c);
        chk(c == 4, "R2 latency", c, 4);
        chk(nreads == 1, "R2 reads", nreads, 1);
        chk(rd_log[0] == 32'h84, "R2 addr", rd_log[0], 32'h84);
        check_target("R2", 16'hF000, 32'h0000_E987, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_intr_gate();
        int c;
        fetch(8'd3, 1'b1, 32'h400, 16'd31, 1'b0, 8'h0, c);
        chk(c == 6, "R5 latency", c, 6);
        chk(nreads == 2, "R3 reads", nreads, 2);
        chk(rd_log[0] == 32'h418, "R3 low addr", rd_log[0], 32'h418);
        chk(rd_log[1] == 32'h41C, "R3 high addr", rd_log[1], 32'h41C);
        check_target("R5 R4 edge", 16'h0008, 32'hC0DE_1234, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_limit();
        int c;
        fetch(8'd4, 1'b1, 32'h400, 16'd31, 1'b0, 8'h0, c);
        chk(c == 2, "R4 latency", c, 2);
        chk(nreads == 0, "R4 no read", nreads, 0);
        check_target("R4", 16'h0, 32'h0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic test_trap_gate();
        int c;
        fetch(8'd4, 1'b1, 32'h400, 16'h3F, 1'b0, 8'h0, c);
        chk(c == 6, "R6 latency", c, 6);
        check_target("R6", 16'h0010, 32'hBEEF_5678, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_task_gate();
        int c;
        fetch(8'd5, 1'b1, 32'h400, 16'h3F, 1'b0, 8'h0, c);
        chk(c == 6, "R7 latency", c, 6);
        check_target("R7", 16'h0028, 32'h0000_0000, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic test_bad_gates();
        int c;
        fetch(8'd6, 1'b1, 32'h400, 16'h3F, 1'b0, 8'h0, c);
        chk(c == 6, "R8 latency", c, 6);
        check_target("R8", 16'h0, 32'h0, 1'b0, 1'b0, 1'b1);
        fetch(8'd7, 1'b1, 32'h400, 16'h3F, 1'b0, 8'h0, c);
        chk(c == 6, "R9 latency", c, 6);
        check_target("R9", 16'h0, 32'h0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic test_busy_and_hold();
        int c;
        fetch(8'd4, 1'b1, 32'h400, 16'h3F, 1'b1, 8'h21, c);
        chk(c == 6, "R10 latency", c, 6);
        check_target("R10", 16'h0010, 32'hBEEF_5678, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) @(negedge clk);
        chk(nreads == 2, "R10 no extra read", nreads, 2);
        chk(ndone == 1, "R11 single done", ndone, 1);
        check_target("R11 hold", 16'h0010, 32'hBEEF_5678, 1'b0, 1'b0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h5A5A_0000 | i;
        mem[10'h021] = 32'hF000_E987;
        mem[10'h106] = 32'h0008_1234; mem[10'h107] = 32'hC0DE_8E00;
        mem[10'h108] = 32'h0010_5678; mem[10'h109] = 32'hBEEF_8F00;
        mem[10'h10A] = 32'h0028_0000; mem[10'h10B] = 32'h0000_8500;
        mem[10'h10C] = 32'h0030_1111; mem[10'h10D] = 32'h2222_0E00;
        mem[10'h10E] = 32'h0038_3333; mem[10'h10F] = 32'h4444_8C00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_real();
        test_intr_gate();
        test_limit();
        test_trap_gate();
        test_task_gate();
        test_bad_gates();
        test_busy_and_hold();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule